// File: doc/BRIEF.md
# Ripple-Through FIFO Buffer

A small first-in first-out buffer built as a chain of data registers. Every register carries its own occupancy flag, so a word written at the entry stage travels one register per clock toward the exit stage, without any read or write pointer. The producer writes while the entry stage is empty. The consumer removes the word at the exit stage while that stage is full. The two sides run at independent rates on one clock.

A word is copied forward on each clock edge when its stage is occupied and the next stage is free. The exit stage also counts as free in a cycle where its word is being removed. An insert or a remove that cannot be honoured is dropped and sets a sticky error flag. A synchronous master clear empties the whole chain. Depth and word width are parameters, with a default of four stages of four bits; at least two stages are required.

Top module: `ripple_fifo`

## Requirements
- R1: A master clear (`mclr` high at a clock edge) leaves every stage empty after that edge: `in_rdy`=1, `out_rdy`=0, `err`=0. Words held before the clear never reach the output.
- R2: A clock edge with `ins`=1 and `in_rdy`=1 loads `din` into the entry stage, and `in_rdy` reads 0 after that edge.
- R3: On an empty buffer, a word inserted at edge k appears with `out_rdy`=1 and `dout` equal to that word after edge k+STAGES-1. This is STAGES cycles counted from the cycle in which the insert is presented.
- R4: Words appear on `dout` in exactly the order in which they were inserted.
- R5: An insert while `in_rdy`=0 changes no stored word and sets `err` to 1 at that edge.
- R6: A remove (`del`=1) while `out_rdy`=0 has no effect on the buffer and sets `err` to 1 at that edge.
- R7: A clock edge with `del`=1 and `out_rdy`=1 discards the exit word. After that edge `out_rdy` is 0, unless a word from the stage before moved into the exit stage at the same edge.
- R8: When a remove and a move into the exit stage happen at the same edge, no word is lost or duplicated. The number of held words changes by accepted inserts minus accepted removes.
- R9: The buffer holds up to STAGES words. Without a remove, the exit word and `out_rdy` stay unchanged.
- R10: Once set, `err` stays 1 until the next master clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| mclr | input | 1 | Synchronous master clear, active high |
| din | input | WIDTH | Word to insert |
| ins | input | 1 | Insert request |
| in_rdy | output | 1 | Entry stage is empty |
| del | input | 1 | Remove request for the exit word |
| dout | output | WIDTH | Word at the exit stage |
| out_rdy | output | 1 | Exit stage holds a word |
| err | output | 1 | Sticky flag for a dropped insert or remove |

## Verification
Every output comes straight from a flag or data register. A request presented before edge k is therefore visible just after edge k: `in_rdy` and `err` change one edge after the request, and a word needs one edge per stage to reach `dout`. The bench changes inputs 1 ns after a rising edge and reads the outputs at that same point, one edge after each applied vector. The expected state in the vector table is worked out stage by stage for each edge. That includes the edge where a remove and a move into the exit stage coincide.

// File: rtl/ripple_fifo.sv
module ripple_fifo #(
  parameter int STAGES = 4,
  parameter int WIDTH  = 4
) (
  input  logic             clk,
  input  logic             mclr,
  input  logic [WIDTH-1:0] din,
  input  logic             ins,
  output logic             in_rdy,
  input  logic             del,
  output logic [WIDTH-1:0] dout,
  output logic             out_rdy,
  output logic             err
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0]            full, full_nx;
  logic [STAGES-1:0][WIDTH-1:0] word;
  logic [STAGES-2:0]            adv;
  logic                         take, drop;

  assign in_rdy  = ~full[0];
  assign out_rdy = full[LAST];
  assign dout    = word[LAST];
  assign take    = ins & ~full[0];
  assign drop    = del & full[LAST];

  always_comb begin
    for (int i = 0; i < LAST - 1; i++)
      adv[i] = full[i] & ~full[i+1];
    adv[LAST-1] = full[LAST-1] & (~full[LAST] | del);
  end

  always_comb begin
    full_nx[0] = (full[0] & ~adv[0]) | take;
    for (int i = 1; i < LAST; i++)
      full_nx[i] = (full[i] & ~adv[i]) | adv[i-1];
    full_nx[LAST] = (full[LAST] & ~drop) | adv[LAST-1];
  end

  always_ff @(posedge clk) begin
    if (mclr) begin
      full <= '0;
      err  <= 1'b0;
    end else begin
      full <= full_nx;
      if ((ins & full[0]) | (del & ~full[LAST]))
        err <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (take) word[0] <= din;
    for (int i = 1; i < STAGES; i++)
      if (adv[i-1]) word[i] <= word[i-1];
  end

  p_clear_r1: assert property (@(posedge clk)
    mclr |=> (in_rdy && !out_rdy && !err));

  p_take_r2: assert property (@(posedge clk) disable iff (mclr)
    (ins && in_rdy) |=> !in_rdy);

  p_ins_blocked_r5: assert property (@(posedge clk) disable iff (mclr)
    (ins && !in_rdy) |=> err);

  p_del_empty_r6: assert property (@(posedge clk) disable iff (mclr)
    (del && !out_rdy) |=> err);

  p_count_r8: assert property (@(posedge clk) disable iff (mclr)
    !$past(mclr) |-> (int'($countones(full)) ==
      int'($past($countones(full))) + int'($past(ins && in_rdy)) - int'($past(del && out_rdy))));

  p_hold_r9: assert property (@(posedge clk) disable iff (mclr)
    (out_rdy && !del) |=> (out_rdy && $stable(dout)));

  p_sticky_r10: assert property (@(posedge clk) disable iff (mclr)
    err |=> err);
endmodule

// File: tb/sim_ripple_fifo.sv
`timescale 1ns/1ps
module sim_ripple_fifo;
  logic       clk = 1'b0;
  logic       mclr = 1'b1;
  logic [3:0] din = '0;
  logic       ins = 1'b0, del = 1'b0;
  logic       in_rdy, out_rdy, err;
  logic [3:0] dout;
  int total = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ripple_fifo #(.STAGES(4), .WIDTH(4)) u0 (
    .clk(clk), .mclr(mclr), .din(din), .ins(ins), .in_rdy(in_rdy),
    .del(del), .dout(dout), .out_rdy(out_rdy), .err(err));

  // {ins, din, del, exp in_rdy, exp out_rdy, exp dout, exp err}
  localparam logic [12:0] VEC [15] = '{
    {1'b1,4'h5,1'b0, 1'b0,1'b0,4'h0,1'b0},   // R2
    {1'b0,4'h0,1'b0, 1'b1,1'b0,4'h0,1'b0},
    {1'b1,4'hA,1'b0, 1'b0,1'b0,4'h0,1'b0},
    {1'b0,4'h0,1'b0, 1'b1,1'b1,4'h5,1'b0},   // R3: four cycles
    {1'b1,4'h3,1'b0, 1'b0,1'b1,4'h5,1'b0},
    {1'b0,4'h0,1'b0, 1'b1,1'b1,4'h5,1'b0},   // R9
    {1'b1,4'hC,1'b0, 1'b0,1'b1,4'h5,1'b0},   // R9 full
    {1'b1,4'h7,1'b0, 1'b0,1'b1,4'h5,1'b1},   // R5
    {1'b0,4'h0,1'b1, 1'b0,1'b1,4'hA,1'b1},   // R8 delete with move
    {1'b0,4'h0,1'b0, 1'b0,1'b1,4'hA,1'b1},
    {1'b0,4'h0,1'b0, 1'b1,1'b1,4'hA,1'b1},
    {1'b0,4'h0,1'b1, 1'b1,1'b1,4'h3,1'b1},   // R8, R4
    {1'b0,4'h0,1'b1, 1'b1,1'b0,4'h0,1'b1},   // R7
    {1'b0,4'h0,1'b0, 1'b1,1'b1,4'hC,1'b1},   // R4
    {1'b0,4'h0,1'b1, 1'b1,1'b0,4'h0,1'b1}    // R7, R10
  };

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic i, input logic [3:0] d, input logic dl);
    ins = i; din = d; del = dl;
    @(posedge clk); #1;
    ins = 1'b0; del = 1'b0;
  endtask

  task automatic clear();
    mclr = 1'b1;
    @(posedge clk); #1;
    mclr = 1'b0;
  endtask

  initial begin
    logic [6:0] obs, exp;
    int sent, got;
    repeat (2) @(posedge clk);
    #1;
    // R1 reset state
    chk(in_rdy && !out_rdy && !err, "R1 reset", {13'b0, in_rdy, out_rdy, err}, 16'h4);
    mclr = 1'b0;

    for (int v = 0; v < 15; v++) begin
      cyc(VEC[v][12], VEC[v][11:8], VEC[v][7]);
      exp = VEC[v][6:0];
      obs = {in_rdy, out_rdy, (out_rdy ? dout : 4'h0), err};
      chk(obs == exp, $sformatf("R2 R3 R4 R5 R7 R8 R9 row %0d", v), {9'b0, obs}, {9'b0, exp});
    end

    // R10: err still set after idle cycles
    cyc(1'b0, 4'h0, 1'b0);
    cyc(1'b0, 4'h0, 1'b0);
    chk(err, "R10 sticky", {15'b0, err}, 16'h1);

    // R1: clear with words inside
    cyc(1'b1, 4'h9, 1'b0);
    cyc(1'b0, 4'h0, 1'b0);
    cyc(1'b1, 4'h6, 1'b0);
    clear();
    chk(in_rdy && !out_rdy && !err, "R1 clear", {13'b0, in_rdy, out_rdy, err}, 16'h4);
    repeat (5) cyc(1'b0, 4'h0, 1'b0);
    chk(!out_rdy, "R1 no stale word", {15'b0, out_rdy}, 16'h0);

    // R6: remove on empty
    cyc(1'b0, 4'h0, 1'b1);
    chk(err && in_rdy && !out_rdy, "R6 del empty", {13'b0, in_rdy, out_rdy, err}, 16'h5);
    clear();

    // R3 with a fresh word, then R7 lone delete
    cyc(1'b1, 4'hE, 1'b0);
    repeat (2) cyc(1'b0, 4'h0, 1'b0);
    chk(!out_rdy, "R3 early", {15'b0, out_rdy}, 16'h0);
    cyc(1'b0, 4'h0, 1'b0);
    chk(out_rdy && dout == 4'hE, "R3 latency", {11'b0, out_rdy, dout}, 16'h1E);
    cyc(1'b0, 4'h0, 1'b1);
    chk(!out_rdy && !err, "R7 delete", {14'b0, out_rdy, err}, 16'h0);

    // R4/R8: streaming at both ends
    sent = 0; got = 0;
    for (int c = 0; c < 300 && got < 12; c++) begin
      ins = in_rdy && sent < 12;
      din = 4'(sent * 3 + 1);
      if (ins) sent++;
      del = out_rdy;
      if (out_rdy) begin
        chk(dout == 4'(got * 3 + 1), "R4 order", {12'b0, dout}, {12'b0, 4'(got * 3 + 1)});
        got++;
      end
      @(posedge clk); #1;
    end
    ins = 1'b0; del = 1'b0;
    chk(got == 12 && !out_rdy && in_rdy && !err, "R8 count", 16'(got), 16'd12);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule